// File: doc/BRIEF.md
# Sixteen-Pin GPIO Expander Core

This block holds the control registers and per-pin logic of a sixteen-pin general-purpose I/O expander. The pins are split into two banks of eight. A host reaches the registers over a simple synchronous byte bus, addressed by register index. A serial slave front end would normally drive this bus, but it sits outside the block. Each function has one byte per bank: output value, direction, input polarity, input latch, pull enable, pull direction and interrupt mask. Drive strength takes two bytes per bank. A single byte sets the output mode (push-pull or open-drain) of each bank.

The pin inputs pass through a synchronizer and then through the per-bit polarity inversion. The result is compared against a snapshot that is taken each time the host reads that bank's input byte. An unmasked difference sets a status bit and pulls the interrupt request line low. When latching is enabled for a pin, the first change on it is held, both in the input byte and as a pending interrupt, until the host reads the bank. On the pad side the block drives a data value, an output enable, pull controls and a 2-bit drive code for every pin.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset, both direction bytes read 0xFF (1 = input), every `pad_oe` bit is 0, and the output, polarity, latch, pull, drive and mode registers are 0.
- R2: After reset, both mask bytes read 0xFF (1 = masked). A masked pin never sets its status bit and never asserts `irq_pull_low`.
- R3: A pin whose direction bit is 0 in a push-pull bank has `pad_oe` = 1 and `pad_out` equal to its output bit.
- R4: When bit b of the mode byte is 1, bank b is open-drain: an output bit of 0 gives `pad_oe` = 1 and `pad_out` = 0, and an output bit of 1 gives `pad_oe` = 0.
- R5: With latching off, an input-byte bit equals the synchronized pin XOR its polarity bit. A pin change shows up after two rising clock edges.
- R6: With latching off, the status bit of an unmasked pin is 1 exactly while its polarity-corrected value differs from the snapshot. `irq_pull_low` is the OR of all status bits, so both clear by themselves when the pin returns.
- R7: A read strobe on an input byte reloads that bank's snapshot from the current values on that edge, which clears the bank's status bits.
- R8: With the latch bit set, the first change on a pin is held. The input byte shows the changed value, and both the status bit and `irq_pull_low` stay set until that bank's input byte is read, even if the pin has gone back.
- R9: Reading one bank's input byte leaves the latched state and the status of the other bank unchanged.
- R10: `pad_pull_en` and `pad_pull_up` follow the pull-enable and pull-select bits (1 = pull up). Pin p of bank b takes its drive code from `pad_drive[32*b/2+2*p +: 2]`, which is held in the byte at index 8+2b+(p/4), bits 2*(p%4) +: 2.
- R11: Pulling `rst_n` low in the middle of operation brings every register back to its R1/R2 value.
- R12: Register indices (bank b is added to the base): input 0, output 2, polarity 4, direction 6, drive 8..11, latch 12, pull enable 14, pull select 16, mask 18, status 20 (read-only), mode 22 (bit b = bank b). Each writable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 5 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (has side effects on input bytes) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current index |
| pin_in | input | 16 | Raw pad input values |
| pad_out | output | 16 | Pad data value |
| pad_oe | output | 16 | Pad output enable |
| pad_pull_en | output | 16 | Pull resistor enable |
| pad_pull_up | output | 16 | Pull direction, 1 = up |
| pad_drive | output | 32 | Drive strength codes, 2 bits per pin |
| irq_pull_low | output | 1 | Interrupt request, 1 = pull the open-drain line low |

## Verification
The bench builds the block with its default parameters: two banks of eight pins and a two-stage synchronizer. With only two banks, it can check that a read of bank 0 leaves a latch pending in bank 1 untouched. The two-edge synchronizer delay gives fixed sampling points for every pin-change check. A latched change followed by the pin returning to its old level shows the held interrupt, and an unlatched change followed by the same return shows the interrupt clearing by itself.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int NBANK  = 2;
    localparam int BANK_W = 8;
    localparam int NPIN   = NBANK * BANK_W;
    localparam int IDX_W  = 5;

    localparam logic [IDX_W-1:0] IDX_IN   = 5'd0;
    localparam logic [IDX_W-1:0] IDX_OUT  = 5'd2;
    localparam logic [IDX_W-1:0] IDX_POL  = 5'd4;
    localparam logic [IDX_W-1:0] IDX_DIR  = 5'd6;
    localparam logic [IDX_W-1:0] IDX_DRV0 = 5'd8;
    localparam logic [IDX_W-1:0] IDX_DRV1 = 5'd10;
    localparam logic [IDX_W-1:0] IDX_LEN  = 5'd12;
    localparam logic [IDX_W-1:0] IDX_PEN  = 5'd14;
    localparam logic [IDX_W-1:0] IDX_PSEL = 5'd16;
    localparam logic [IDX_W-1:0] IDX_MASK = 5'd18;
    localparam logic [IDX_W-1:0] IDX_STAT = 5'd20;
    localparam logic [IDX_W-1:0] IDX_MODE = 5'd22;

    typedef logic [NBANK-1:0][BANK_W-1:0]   bank_byte_t;
    typedef logic [NBANK-1:0][2*BANK_W-1:0] bank_drv_t;

    typedef struct packed {
        bank_byte_t        outv;
        bank_byte_t        pol;
        bank_byte_t        dir;
        bank_byte_t        len;
        bank_byte_t        pen;
        bank_byte_t        psel;
        bank_byte_t        mask;
        bank_drv_t         drv;
        logic [NBANK-1:0]  od;
    } regs_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpx_bank_input.sv
module gpx_bank_input #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic [W-1:0] latch_en,
    input  logic [W-1:0] mask,
    input  logic         rd_clr,
    output logic [W-1:0] view,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] snap;
        logic [W-1:0] lat;
        logic [W-1:0] latv;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] chg, pend;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            chg[i]  = live[i] ^ st_q.snap[i];
            pend[i] = chg[i] | (latch_en[i] & st_q.lat[i]);
            view[i] = (latch_en[i] & st_q.lat[i]) ? st_q.latv[i] : live[i];
            st_d.lat[i]  = latch_en[i] & (st_q.lat[i] | chg[i]);
            st_d.latv[i] = st_q.lat[i] ? st_q.latv[i] : live[i];
        end
        if (rd_clr) begin
            st_d.snap = live;
            st_d.lat  = '0;
            st_d.latv = live;
        end
        status = pend & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((st_q.lat & $past(st_q.lat & latch_en)) == $past(st_q.lat & latch_en)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (st_q.lat == '0));
endmodule

// File: rtl/gpx_pad_drive.sv
module gpx_pad_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] outv,
    input  logic         od,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    always_comb begin
        for (int i = 0; i < W; i++) begin
            pad_oe[i]  = ~dir[i] & (~od | ~outv[i]);
            pad_out[i] = od ? 1'b0 : outv[i];
        end
    end
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pull_en,
    output logic [NPIN-1:0]   pad_pull_up,
    output logic [2*NPIN-1:0] pad_drive,
    output logic              irq_pull_low
);
    regs_t regs_d, regs_q;
    logic [NPIN-1:0] sync_pins;
    bank_byte_t live, view, status;
    logic [NBANK-1:0] rd_clr;
    logic [IDX_W-1:0] base;
    logic bsel;

    assign base = {reg_idx[IDX_W-1:1], 1'b0};
    assign bsel = reg_idx[0];

    gpx_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_pins)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign live[b]   = sync_pins[b*BANK_W +: BANK_W] ^ regs_q.pol[b];
        assign rd_clr[b] = reg_rd && (reg_idx == IDX_IN + IDX_W'(b));

        gpx_bank_input #(.W(BANK_W)) u_in (
            .clk(clk), .rst_n(rst_n), .live(live[b]), .latch_en(regs_q.len[b]),
            .mask(regs_q.mask[b]), .rd_clr(rd_clr[b]), .view(view[b]),
            .status(status[b])
        );

        gpx_pad_drive #(.W(BANK_W)) u_pad (
            .dir(regs_q.dir[b]), .outv(regs_q.outv[b]), .od(regs_q.od[b]),
            .pad_out(pad_out[b*BANK_W +: BANK_W]), .pad_oe(pad_oe[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            case (base)
                IDX_OUT:  regs_d.outv[bsel] = reg_wdata;
                IDX_POL:  regs_d.pol[bsel]  = reg_wdata;
                IDX_DIR:  regs_d.dir[bsel]  = reg_wdata;
                IDX_LEN:  regs_d.len[bsel]  = reg_wdata;
                IDX_PEN:  regs_d.pen[bsel]  = reg_wdata;
                IDX_PSEL: regs_d.psel[bsel] = reg_wdata;
                IDX_MASK: regs_d.mask[bsel] = reg_wdata;
                IDX_DRV0, IDX_DRV1:
                    regs_d.drv[reg_idx[1]][{reg_idx[0], 3'b000} +: 8] = reg_wdata;
                IDX_MODE: if (!bsel) regs_d.od = reg_wdata[NBANK-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (base)
            IDX_IN:   reg_rdata = view[bsel];
            IDX_OUT:  reg_rdata = regs_q.outv[bsel];
            IDX_POL:  reg_rdata = regs_q.pol[bsel];
            IDX_DIR:  reg_rdata = regs_q.dir[bsel];
            IDX_LEN:  reg_rdata = regs_q.len[bsel];
            IDX_PEN:  reg_rdata = regs_q.pen[bsel];
            IDX_PSEL: reg_rdata = regs_q.psel[bsel];
            IDX_MASK: reg_rdata = regs_q.mask[bsel];
            IDX_STAT: reg_rdata = status[bsel];
            IDX_DRV0, IDX_DRV1:
                reg_rdata = regs_q.drv[reg_idx[1]][{reg_idx[0], 3'b000} +: 8];
            IDX_MODE: if (!bsel) reg_rdata = {{(8-NBANK){1'b0}}, regs_q.od};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.dir  <= '1;
            regs_q.mask <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pad_pull_en  = regs_q.pen;
    assign pad_pull_up  = regs_q.psel;
    assign pad_drive    = regs_q.drv;
    assign irq_pull_low = |status;

    // R1
    dir_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q.dir == '1 && pad_oe == '0));

    // R2
    mask_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q.mask == '1 && !irq_pull_low));

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & regs_q.mask) == '0);

    // R3
    oe_only_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & regs_q.dir) == '0);

    // R4
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & {{BANK_W{regs_q.od[1]}}, {BANK_W{regs_q.od[0]}}}) == '0));
endmodule

// File: tb/gpio_expander_core_test.sv
module gpio_expander_core_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  reg_idx = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [31:0] pad_drive;
    logic        irq_pull_low;

    int checks = 0, errors = 0;
    logic chk_go = 0;
    bit done = 0;

    typedef struct { int sel; logic [31:0] exp; string req; } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    gpio_expander_core uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .pad_drive(pad_drive), .irq_pull_low(irq_pull_low)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        if (chk_go && q.size() > 0) begin
            it = q.pop_front();
            case (it.sel)
                0: act = {24'h0, reg_rdata};
                1: act = {31'h0, irq_pull_low};
                2: act = {16'h0, pad_oe};
                3: act = {16'h0, pad_out};
                4: act = {16'h0, pad_pull_en};
                5: act = {16'h0, pad_pull_up};
                default: act = pad_drive;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic probe(int sel, logic [31:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
        chk_go = 1;
        @(posedge clk); #1;
        chk_go = 0;
    endtask

    task automatic rd(logic [4:0] idx, logic [7:0] exp, string req);
        reg_idx = idx;
        reg_rd  = 1;
        probe(0, {24'h0, exp}, req);
        reg_rd  = 0;
    endtask

    task automatic wr(logic [4:0] idx, logic [7:0] val);
        reg_idx = idx; reg_wdata = val; reg_wr = 1;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic pins(logic [15:0] v);
        pin_in = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // reset state
        rd(6, 8'hFF, "R1 dir0");
        rd(7, 8'hFF, "R1 dir1");
        probe(2, 32'h0, "R1 pad_oe");
        rd(18, 8'hFF, "R2 mask0");
        rd(19, 8'hFF, "R2 mask1");
        probe(1, 32'h0, "R2 irq");
        // outputs
        wr(2, 8'hA5);
        wr(6, 8'h00);
        probe(2, 32'h00FF, "R3 oe");
        probe(3, 32'h00A5, "R3 out");
        wr(22, 8'h01);
        rd(22, 8'h01, "R12 mode readback");
        probe(2, 32'h005A, "R4 od oe");
        probe(3, 32'h0000, "R4 od out");
        // inputs and polarity
        pins(16'h3C00);
        rd(1, 8'h3C, "R5 raw");
        probe(1, 32'h0, "R2 masked change");
        rd(21, 8'h00, "R2 masked status");
        wr(5, 8'h0F);
        rd(1, 8'h33, "R5 inverted");
        // unlatched interrupt
        wr(19, 8'hFE);
        pins(16'h3D00);
        probe(1, 32'h1, "R6 irq set");
        rd(21, 8'h01, "R6 status");
        pins(16'h3C00);
        probe(1, 32'h0, "R6 self clear");
        pins(16'h3D00);
        rd(1, 8'h32, "R7 read value");
        probe(1, 32'h0, "R7 irq cleared");
        rd(21, 8'h00, "R7 status cleared");
        // latched interrupt
        wr(13, 8'h01);
        pins(16'h3C00);
        pins(16'h3D00);
        probe(1, 32'h1, "R8 held irq");
        rd(21, 8'h01, "R8 held status");
        rd(0, 8'h00, "R9 other bank read");
        probe(1, 32'h1, "R9 irq survives");
        rd(1, 8'h33, "R8 latched value");
        probe(1, 32'h0, "R8 cleared by read");
        // pulls and drive
        wr(14, 8'hF0);
        wr(16, 8'h30);
        wr(8, 8'hE4);
        wr(11, 8'h1B);
        probe(4, 32'h00F0, "R10 pull en");
        probe(5, 32'h0030, "R10 pull up");
        probe(6, 32'h1B0000E4, "R10 drive");
        rd(11, 8'h1B, "R12 drive readback");
        // reset mid-run
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        rd(6, 8'hFF, "R11 dir0");
        rd(19, 8'hFF, "R11 mask1");
        probe(2, 32'h0, "R11 pad_oe");
        probe(6, 32'h0, "R11 drive");
        rd(5, 8'h00, "R11 polarity");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule